// File: doc/BRIEF.md
# Shared Bus Arbiter with Host Path and Lock

This block decides which of several masters drives one shared external bus. Up to six processor masters each raise a request and receive a grant. A host master has its own request and grant pair. It also has a ready output that tells the host the bus is settled in its hands. One grant at most is active at any time.

When the bus is free, a pending host request wins. If no host request is pending, a processor is chosen, either by fixed index order or by a rotating order that starts just after the processor granted last. The current owner keeps the bus while its request stays high. A lock input from the owner also keeps the bus, even after the request falls, so that read-modify-write sequences stay indivisible. When the owner lets go, the bus stays idle for exactly one cycle before the next grant.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every processor grant, the host grant and host ready are low.
- R2: At most one of the processor grants and the host grant is high in any cycle.
- R3: When no grant is active, the requests sampled at a clock edge decide the grant that is visible after that edge. A master is only granted if its request was high at that edge.
- R4: An owner whose request stays high keeps its grant, whatever the other requests do.
- R5: When the owner's request is low and lock is low at an edge, all grants are low for exactly one cycle. The next master is then chosen at the following edge.
- R6: While lock is high and a grant is active, the active grant does not change, even if the owner's request is low and the host is requesting.
- R7: When the bus is free and the host request is high, the host is granted ahead of every processor request.
- R8: With the rotate input low, the requesting processor with the lowest index (bit 0 of the request vector) is granted.
- R9: With the rotate input high, the search starts at the index after the processor granted most recently and wraps from the top index to 0. After reset the search starts at index 0.
- R10: Host ready rises one cycle after the host grant rises, stays high while the grant holds, and falls together with the grant.
- R11: The rotate input only matters at the edge where a grant is chosen, and it can change between grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_req | input | NPROC | Processor bus requests, bit i from processor i |
| proc_gnt | output | NPROC | Processor bus grants, one-hot or zero |
| host_req | input | 1 | Host bus request |
| host_gnt | output | 1 | Host bus grant |
| host_ready | output | 1 | Host owns a settled bus |
| rotate | input | 1 | 1 selects rotating processor priority, 0 selects fixed |
| lock | input | 1 | Owner holds the bus regardless of its request |

## Verification
The hardest case to reach is a locked owner that has already dropped its request while the host and several processors wait. Handover then depends on lock alone, and on the rotation pointer left by earlier grants. Directed phases build this state on purpose: a processor is granted, lock is raised, its request is dropped and the host request is raised. Lock is then released, and the bench expects the single dead cycle followed by the host grant. A long random phase then mixes lock, rotate and requests. A behavioural model is compared on every clock.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NPROC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] proc_req,
  output logic [NPROC-1:0] proc_gnt,
  input  logic             host_req,
  output logic             host_gnt,
  output logic             host_ready,
  input  logic             rotate,
  input  logic             lock
);
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1;

  logic [IW-1:0]    last_q;
  logic [NPROC-1:0] pick;
  logic [IW-1:0]    pick_idx;
  logic             pick_any;
  logic [NPROC-1:0] gnt_d;
  logic             host_d;
  logic             busy, keep;

  assign busy = host_gnt | (|proc_gnt);
  assign keep = lock | (host_gnt & host_req) | (|(proc_gnt & proc_req));

  always_comb begin
    pick     = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int k = 1; k <= NPROC; k++) begin
      int idx;
      idx = rotate ? ((int'(last_q) + k) % NPROC) : (k - 1);
      if (!pick_any && proc_req[idx]) begin
        pick_any  = 1'b1;
        pick[idx] = 1'b1;
        pick_idx  = IW'(idx);
      end
    end
  end

  always_comb begin
    if (busy) begin
      host_d = keep & host_gnt;
      gnt_d  = keep ? proc_gnt : '0;
    end else begin
      host_d = host_req;
      gnt_d  = host_req ? '0 : pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proc_gnt   <= '0;
      host_gnt   <= 1'b0;
      host_ready <= 1'b0;
      last_q     <= IW'(NPROC - 1);
    end else begin
      proc_gnt   <= gnt_d;
      host_gnt   <= host_d;
      host_ready <= host_d & host_gnt;
      if (!busy && !host_req && pick_any) last_q <= pick_idx;
    end
  end

  assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_gnt, proc_gnt}));

  assert_dead_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!(host_gnt | (|proc_gnt)) || $stable({host_gnt, proc_gnt})));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lock) |=> $stable({host_gnt, proc_gnt}));

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(proc_gnt & proc_req)) |=> $stable(proc_gnt));

  assert_req_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((proc_gnt & ~$past(proc_req)) == '0 && (!host_gnt || $past(host_req))));

  assert_host_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_req) |=> host_gnt);

  assert_ready_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> host_gnt);

  assert_ready_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> !host_ready);
endmodule

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] proc_req = '0;
  logic host_req = 1'b0, rotate = 1'b0, lock = 1'b0;
  logic [N-1:0] proc_gnt;
  logic host_gnt, host_ready;
  int checks = 0, errors = 0;
  string tag = "R1";

  // model state: owner -1 none, 0..N-1 processor, N host
  int m_owner = -1, m_last = N - 1;
  bit m_ready = 0;

  always #2.5 clk = ~clk;

  bus_arbiter #(.NPROC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_req(proc_req), .proc_gnt(proc_gnt),
    .host_req(host_req), .host_gnt(host_gnt), .host_ready(host_ready),
    .rotate(rotate), .lock(lock));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_owner = -1; m_last = N - 1; m_ready = 0;
    end else begin
      int prev;
      prev = m_owner;
      if (m_owner >= 0) begin
        bit rq;
        rq = (m_owner == N) ? host_req : proc_req[m_owner];
        if (!rq && !lock) m_owner = -1;
      end else if (host_req) begin
        m_owner = N;
      end else begin
        for (int k = 0; k < N; k++) begin
          int i;
          i = rotate ? (m_last + 1 + k) % N : k;
          if (m_owner < 0 && proc_req[i]) m_owner = i;
        end
        if (m_owner >= 0) m_last = m_owner;
      end
      m_ready = (m_owner == N) && (prev == N);
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [N-1:0] ep;
    @(negedge clk);
    ep = (m_owner >= 0 && m_owner < N) ? (N'(1) << m_owner) : '0;
    chk(proc_gnt == ep, {tag, " proc_gnt"}, int'(proc_gnt), int'(ep));
    chk(host_gnt == (m_owner == N), {tag, " host_gnt"}, int'(host_gnt), int'(m_owner == N));
    chk(host_ready == m_ready, {tag, " host_ready"}, int'(host_ready), int'(m_ready));
    chk($countones({host_gnt, proc_gnt}) <= 1, "R2 one owner", int'({host_gnt, proc_gnt}), 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R1"; proc_req = '1; host_req = 1'b1;
    run(3);
    chk(proc_gnt == 0 && !host_gnt && !host_ready, "R1 reset idle", int'({host_ready, host_gnt, proc_gnt}), 0);
    proc_req = '0; host_req = 1'b0;
    rst_n = 1'b1; run(1);
    chk(proc_gnt == 0 && !host_gnt, "R1 after reset", int'({host_gnt, proc_gnt}), 0);

    tag = "R3"; proc_req = 6'b000100; run(1);
    chk(proc_gnt == 6'b000100, "R3 idle grant", int'(proc_gnt), 4);
    tag = "R4"; proc_req = 6'b110111; run(4);
    chk(proc_gnt == 6'b000100, "R4 keep", int'(proc_gnt), 4);
    tag = "R5"; proc_req = 6'b110011; run(1);
    chk(proc_gnt == 0, "R5 dead cycle", int'(proc_gnt), 0);
    run(1);
    tag = "R8"; chk(proc_gnt == 6'b000001, "R8 lowest index", int'(proc_gnt), 1);
    proc_req = 6'b110010; run(2);
    chk(proc_gnt == 6'b000010, "R8 next lowest", int'(proc_gnt), 2);
    proc_req = 6'b000000; run(2);

    tag = "R9"; rotate = 1'b1; proc_req = '1; run(1);
    for (int r = 0; r < 8; r++) begin
      int cur;
      cur = -1;
      for (int b = 0; b < N; b++) if (proc_gnt[b]) cur = b;
      proc_req[cur] = 1'b0; run(1);
      proc_req[cur] = 1'b1; run(1);
      chk(proc_gnt == (N'(1) << ((cur + 1) % N)), "R9 rotate next", int'(proc_gnt), 1 << ((cur + 1) % N));
    end

    tag = "R11"; rotate = 1'b0; proc_req = '0; run(2);
    proc_req = 6'b100001; run(1);
    chk(proc_gnt == 6'b000001, "R11 fixed again", int'(proc_gnt), 1);
    proc_req = 6'b100000; run(2);
    proc_req = 6'b100011; rotate = 1'b1; run(3);
    proc_req = 6'b000011; run(2);
    chk(proc_gnt == 6'b000001, "R11 rotate wrap", int'(proc_gnt), 1);

    tag = "R7"; proc_req = 6'b000010; host_req = 1'b1; run(2);
    proc_req = 6'b011110; run(2);
    chk(host_gnt && proc_gnt == 0, "R7 host first", int'({host_gnt, proc_gnt}), 64);
    tag = "R10"; run(1);
    chk(host_ready, "R10 ready high", int'(host_ready), 1);
    host_req = 1'b0; run(1);
    chk(!host_ready && !host_gnt, "R10 ready falls", int'({host_ready, host_gnt}), 0);

    tag = "R6"; host_req = 1'b0; proc_req = 6'b001000; rotate = 1'b0; run(2);
    lock = 1'b1; proc_req = 6'b000001; host_req = 1'b1; run(5);
    chk(proc_gnt == 6'b001000 && !host_gnt, "R6 lock hold", int'({host_gnt, proc_gnt}), 8);
    lock = 1'b0; run(1);
    chk(proc_gnt == 0 && !host_gnt, "R6 release gap", int'({host_gnt, proc_gnt}), 0);
    run(1);
    chk(host_gnt, "R6 host after unlock", int'(host_gnt), 1);
    host_req = 1'b0; proc_req = '0; run(3);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      proc_req = N'($urandom);
      if ($urandom % 4 == 0) host_req = ~host_req;
      lock = ($urandom % 6 == 0);
      if ($urandom % 50 == 0) rotate = ~rotate;
      run(1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule